// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block keeps the status register of a serial non-volatile memory and decides which commands may change the memory or the register. It sits after the instruction decoder. It receives one-cycle command strobes for write enable, write disable, status write (with a data byte) and memory write (with an address). It also receives the active-low protect pin and a strobe that marks the end of the internal write cycle. It answers each command with a one-cycle accept or reject pulse, and it shows the live status byte.

A sticky register-lock bit, together with a low level on the protect pin, locks the status register against any change. Two protect bits pick which upper fraction of the array refuses writes. A status write does not act at once: the lock bit and protect bits keep their old values until the internal cycle ends, and only then do the new values appear.

Top module: `spi_wprot_ctrl`

## Requirements
- R1: After reset, `status` is 8'h00 and neither `cmd_accept` nor `cmd_reject` is high.
- R2: A write-enable strobe sets the enable latch (`status[1]`). A write-disable strobe clears it. Each of these strobes is accepted.
- R3: A status write with the enable latch clear is rejected.
- R4: With the lock bit (`status[7]`) at 0, a status write with the latch set is accepted whatever the level of `wp_n`.
- R5: With the lock bit at 1 and `wp_n` high, a status write with the latch set is accepted.
- R6: With the lock bit at 1 and `wp_n` low, a status write is rejected. A rejected command of any kind leaves every status bit unchanged, including the enable latch.
- R7: While an accepted write cycle runs, `status[0]` reads 1 and the lock bit and protect bits keep their old values. The new lock and protect values appear in the cycle after `cyc_done`.
- R8: The protect bits `status[3:2]` select the protected area from the top two address bits: 00 protects nothing, 01 protects the top quarter (top bits 11), 10 protects the top half (top bit 1), and 11 protects the whole array. `addr_writable` is 0 inside that area and 1 outside it.
- R9: A memory write is accepted only when the enable latch is set and the address lies outside the protected area. Otherwise it is rejected. This holds with or without the hardware lock.
- R10: While `status[0]` is 1, status-write and memory-write strobes are ignored: no accept pulse, no reject pulse, no status change.
- R11: The enable latch and `status[0]` clear in the cycle after `cyc_done` ends an accepted write or status write.
- R12: Status bits 6..4 always read 0, whatever data byte is written.
- R13: `cmd_accept` and `cmd_reject` pulse for one clock, in the cycle after the strobe, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Active-low protect pin |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_wrsr | input | 1 | Status-write command strobe |
| wrsr_data | input | 8 | Data byte for the status write |
| cmd_write | input | 1 | Memory-write command strobe |
| write_addr | input | ADDR_W | Target address of the memory write |
| cyc_done | input | 1 | End of the internal write cycle |
| status | output | 8 | {lock, 0, 0, 0, protect[1:0], enable latch, busy} |
| cmd_accept | output | 1 | One-cycle accept pulse |
| cmd_reject | output | 1 | One-cycle reject pulse |
| addr_writable | output | 1 | `write_addr` lies outside the protected area |

## Verification
Status writes are tried under all four combinations of lock bit and pin level, plus once with the latch clear. This separates a missing latch check from a missing pin check. An all-ones data byte is written so that any reserved bit reaching the register shows up. Addresses in each quarter of the array are checked under every protect code, which tells apart off-by-one region boundaries. Strobes issued during a running cycle, and protect values read before and after `cyc_done`, show whether updates are deferred and whether busy commands are dropped.

// File: rtl/spi_wprot_ctrl.sv
module spi_wprot_ctrl #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] write_addr,
  input  logic              cyc_done,
  output logic [7:0]        status,
  output logic              cmd_accept,
  output logic              cmd_reject,
  output logic              addr_writable
);
  localparam int TOP = ADDR_W - 1;

  logic       lock, wel, busy, pend_sr, pend_lock;
  logic [1:0] prot, pend_prot;
  logic [1:0] region;
  logic       in_area, hw_locked, sr_ok, wr_ok;

  assign region    = write_addr[TOP -: 2];
  assign in_area   = (prot == 2'b11) ||
                     (prot == 2'b10 && region[1]) ||
                     (prot == 2'b01 && region == 2'b11);
  assign addr_writable = !in_area;
  assign hw_locked = lock && !wp_n;
  assign sr_ok     = wel && !hw_locked;
  assign wr_ok     = wel && !in_area;
  assign status    = {lock, 3'b000, prot, wel, busy};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock       <= 1'b0;
      prot       <= 2'b00;
      wel        <= 1'b0;
      busy       <= 1'b0;
      pend_sr    <= 1'b0;
      pend_lock  <= 1'b0;
      pend_prot  <= 2'b00;
      cmd_accept <= 1'b0;
      cmd_reject <= 1'b0;
    end else begin
      cmd_accept <= 1'b0;
      cmd_reject <= 1'b0;
      if (busy && cyc_done) begin
        busy <= 1'b0;
        wel  <= 1'b0;
        if (pend_sr) begin
          lock <= pend_lock;
          prot <= pend_prot;
        end
      end
      if (cmd_wrsr) begin
        if (!busy) begin
          if (sr_ok) begin
            cmd_accept <= 1'b1;
            busy       <= 1'b1;
            pend_sr    <= 1'b1;
            pend_lock  <= wrsr_data[7];
            pend_prot  <= wrsr_data[3:2];
          end else begin
            cmd_reject <= 1'b1;
          end
        end
      end else if (cmd_write) begin
        if (!busy) begin
          if (wr_ok) begin
            cmd_accept <= 1'b1;
            busy       <= 1'b1;
            pend_sr    <= 1'b0;
          end else begin
            cmd_reject <= 1'b1;
          end
        end
      end else if (cmd_wren) begin
        wel        <= 1'b1;
        cmd_accept <= 1'b1;
      end else if (cmd_wrdi) begin
        wel        <= 1'b0;
        cmd_accept <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_wprot_chk.sv
module spi_wprot_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_n,
  input logic              cmd_wrsr,
  input logic              cmd_write,
  input logic              cyc_done,
  input logic [ADDR_W-1:0] write_addr,
  input logic [7:0]        status,
  input logic              cmd_accept,
  input logic              cmd_reject,
  input logic              addr_writable
);
  // R6
  hw_lock_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && status[7] && !wp_n && !status[0]) |=> cmd_reject);

  // R6
  reject_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> status == $past(status));

  // R7
  frozen_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> $stable(status[7:2]));

  // R9
  protected_write_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_write && !cmd_wrsr && !status[0] && !addr_writable) |=> cmd_reject);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_wrsr || cmd_write) && status[0] && !cyc_done) |=> !cmd_accept && !cmd_reject);

  // R12
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:4] == 3'b000);

  // R13
  exclusive_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_accept && cmd_reject));
endmodule

bind spi_wprot_ctrl spi_wprot_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_wrsr(cmd_wrsr),
  .cmd_write(cmd_write), .cyc_done(cyc_done), .write_addr(write_addr),
  .status(status), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
  .addr_writable(addr_writable)
);

// File: tb/sim_spi_wprot_ctrl.sv
`timescale 1ns/1ps
module sim_spi_wprot_ctrl;
  localparam int AW = 17;

  logic clk = 1'b0, rst_n = 1'b0, wp_n = 1'b1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0, cyc_done = 0;
  logic [7:0] wrsr_data = 8'h00;
  logic [AW-1:0] write_addr = '0;
  logic [7:0] status;
  logic cmd_accept, cmd_reject, addr_writable;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  spi_wprot_ctrl #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_write(cmd_write),
    .write_addr(write_addr), .cyc_done(cyc_done), .status(status),
    .cmd_accept(cmd_accept), .cmd_reject(cmd_reject), .addr_writable(addr_writable)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] addr_of(input logic [1:0] top);
    return {top, {(AW-2){1'b0}}} | AW'(17'h0155);
  endfunction

  // kind: 0 wren, 1 wrdi, 2 wrsr, 3 write, 4 cyc_done
  task automatic issue(input int kind, input logic [7:0] d, input logic [1:0] top,
                       input string req, input logic exp_acc, input logic exp_rej);
    @(negedge clk);
    wrsr_data  = d;
    write_addr = addr_of(top);
    case (kind)
      0: cmd_wren = 1;
      1: cmd_wrdi = 1;
      2: cmd_wrsr = 1;
      3: cmd_write = 1;
      default: cyc_done = 1;
    endcase
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_write, cyc_done} = '0;
    check({req, " accept"}, {7'b0, cmd_accept}, {7'b0, exp_acc});
    check({req, " reject"}, {7'b0, cmd_reject}, {7'b0, exp_rej});
    @(negedge clk);
    check({req, " pulse width"}, {6'b0, cmd_accept, cmd_reject}, 8'h00);
  endtask

  task automatic region_check(input logic [3:0] exp_wr, input string req);
    for (int t = 0; t < 4; t++) begin
      write_addr = addr_of(2'(t));
      #1;
      check(req, {7'b0, addr_writable}, {7'b0, exp_wr[t]});
    end
  endtask

  task automatic t_reset;
    check("R1 status", status, 8'h00);
    check("R1 responses", {6'b0, cmd_accept, cmd_reject}, 8'h00);
  endtask

  task automatic t_latch;
    issue(0, 8'h00, 2'd0, "R2 wren", 1, 0);
    check("R2 latch set", status, 8'h02);
    issue(1, 8'h00, 2'd0, "R2 wrdi", 1, 0);
    check("R2 latch clear", status, 8'h00);
    issue(2, 8'h8C, 2'd0, "R3 no latch", 0, 1);
    check("R3 status kept", status, 8'h00);
  endtask

  task automatic t_unlocked_pin_low;
    wp_n = 0;
    issue(0, 8'h00, 2'd0, "R4 wren", 1, 0);
    issue(2, 8'hFF, 2'd0, "R4 wrsr pin low", 1, 0);
    check("R7 frozen during cycle", status, 8'h03);
    region_check(4'b1111, "R7 old protect in use");
    issue(2, 8'h00, 2'd0, "R10 wrsr while busy", 0, 0);
    check("R10 status unchanged", status, 8'h03);
    issue(4, 8'h00, 2'd0, "R7 done", 0, 0);
    check("R7 R11 R12 new value", status, 8'h8C);
    region_check(4'b0000, "R8 code 11");
  endtask

  task automatic t_hw_lock;
    issue(0, 8'h00, 2'd0, "R6 wren", 1, 0);
    check("R6 latch", status, 8'h8E);
    issue(2, 8'h00, 2'd0, "R6 locked wrsr", 0, 1);
    check("R6 status kept", status, 8'h8E);
    issue(3, 8'h00, 2'd0, "R9 locked mem write", 0, 1);
    check("R9 status kept", status, 8'h8E);
  endtask

  task automatic t_locked_pin_high;
    wp_n = 1;
    issue(2, 8'h84, 2'd0, "R5 wrsr pin high", 1, 0);
    issue(4, 8'h00, 2'd0, "R5 done", 0, 0);
    check("R5 status", status, 8'h84);
    region_check(4'b0111, "R8 code 01");
    issue(0, 8'h00, 2'd0, "R8 wren", 1, 0);
    issue(2, 8'h08, 2'd0, "R8 wrsr half", 1, 0);
    issue(4, 8'h00, 2'd0, "R8 done", 0, 0);
    check("R8 status", status, 8'h08);
    region_check(4'b0011, "R8 code 10");
  endtask

  task automatic t_mem_write;
    issue(3, 8'h00, 2'd1, "R9 no latch", 0, 1);
    issue(0, 8'h00, 2'd0, "R9 wren", 1, 0);
    issue(3, 8'h00, 2'd3, "R9 protected addr", 0, 1);
    check("R9 latch kept", status, 8'h0A);
    issue(3, 8'h00, 2'd1, "R9 free addr", 1, 0);
    check("R9 busy", status, 8'h0B);
    issue(3, 8'h00, 2'd0, "R10 write while busy", 0, 0);
    check("R10 status", status, 8'h0B);
    issue(4, 8'h00, 2'd0, "R11 done", 0, 0);
    check("R11 latch cleared", status, 8'h08);
    issue(0, 8'h00, 2'd0, "R8 wren", 1, 0);
    issue(2, 8'h70, 2'd0, "R8 wrsr none", 1, 0);
    issue(4, 8'h00, 2'd0, "R8 done", 0, 0);
    check("R12 R8 status", status, 8'h00);
    region_check(4'b1111, "R8 code 00");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_latch;
    t_unlocked_pin_low;
    t_hw_lock;
    t_locked_pin_high;
    t_mem_write;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule